// File: doc/BRIEF.md
# Sixteen-channel two-bit fault status store

This block keeps the health status of sixteen low-side output channels. Each channel reports three raw fault conditions: overload (this covers shorts to supply and overtemperature), open load and short to ground. A fault is accepted only after it has been present for a programmable number of clock cycles. The accepted fault is then held as a two-bit code per channel. The channels form two banks of eight. A serial interface reads one bank at a time.

A read strobe with a bank select copies that bank's sixteen code bits into a snapshot word, together with a one-bit-per-channel summary. The same clock edge returns the bank to the healthy state. The other bank keeps its contents. An active-low flag shows whether any channel anywhere holds a fault, so firmware can wait for an interrupt instead of polling.

Top module: `fault_diag_bank`

## Requirements
- R1: After reset every channel code is 11, `fault_n` is 1, and `rd_word` and `rd_sum` read all ones.
- R2: Code values are 11 healthy, 10 overload, 01 open load and 00 short to ground. When several raw faults are present together, overload wins over short to ground, and short to ground wins over open load.
- R3: Bank 0 holds channels 0 to 7 and bank 1 holds channels 8 to 15. Within a bank, channel i sits in bits 2i+1:2i of `rd_word`, so the highest channel is in bits 15:14.
- R4: A raw fault is latched only when it has been sampled on FILT_CYCLES+1 consecutive clock edges. One edge with no raw fault restarts the count.
- R5: A later accepted fault on a channel overwrites the code latched there before.
- R6: On the edge that samples `rd_stb`, the bank chosen by `rd_bank` is copied into `rd_word` and that bank's codes return to 11. The other bank is not changed.
- R7: A fault still present after its bank has been cleared is latched again only after a full new delay, counted from the read edge.
- R8: `fault_n` is 0 exactly while at least one of the sixteen codes is not 11.
- R9: Bit i of `rd_sum` is 1 when channel i of the snapshot bank reads 11, and 0 otherwise.
- R10: `rd_word` and `rd_sum` hold their values between read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flt_ovl | input | 16 | Raw overload fault per channel |
| flt_open | input | 16 | Raw open-load fault per channel |
| flt_shg | input | 16 | Raw short-to-ground fault per channel |
| rd_stb | input | 1 | Bank read and clear strobe |
| rd_bank | input | 1 | Bank select for the read |
| rd_word | output | 16 | Two-bit codes of the bank last read |
| rd_sum | output | 8 | One-bit healthy summary of the bank last read |
| fault_n | output | 1 | Low while any channel holds a fault |

## Verification
A wrong filter count shows on `fault_n` as a fall one edge early or late relative to the raw fault, and the bench probes both sides of the threshold. A wrong clear shows as a stale code at the next read of the same bank, or as a changed code in the other bank. Those faults appear one read later, so the bench reads both banks back to back. A wrong code or bit position shows in the very next snapshot word. A reference model runs every cycle, so any divergence on `fault_n` is reported on the cycle it happens.

// File: rtl/fault_diag_bank.sv
module fault_diag_bank #(
  parameter int BANK_CH     = 8,
  parameter int NBANK       = 2,
  parameter int FILT_CYCLES = 5000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [BANK_CH*NBANK-1:0]      flt_ovl,
  input  logic [BANK_CH*NBANK-1:0]      flt_open,
  input  logic [BANK_CH*NBANK-1:0]      flt_shg,
  input  logic                          rd_stb,
  input  logic [(NBANK>1 ? $clog2(NBANK) : 1)-1:0] rd_bank,
  output logic [2*BANK_CH-1:0]          rd_word,
  output logic [BANK_CH-1:0]            rd_sum,
  output logic                          fault_n
);
  localparam int NCH = BANK_CH * NBANK;
  localparam int WW  = 2 * BANK_CH;
  localparam int BW  = NBANK > 1 ? $clog2(NBANK) : 1;
  localparam int CW  = $clog2(FILT_CYCLES + 1);

  logic [2*NCH-1:0] code_all;
  logic [WW-1:0]    sel_word;
  logic [BANK_CH-1:0] sel_sum;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int B = c / BANK_CH;
    logic [CW-1:0] cnt;
    logic [1:0]    code, raw;
    logic          hit;

    assign raw = flt_ovl[c] ? 2'b10 :
                 flt_shg[c] ? 2'b00 :
                 flt_open[c] ? 2'b01 : 2'b11;
    assign hit = rd_stb && (rd_bank == B[BW-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        code <= 2'b11;
      end else if (hit) begin
        cnt  <= '0;
        code <= 2'b11;
      end else begin
        if (raw == 2'b11) cnt <= '0;
        else if (cnt != CW'(FILT_CYCLES)) cnt <= cnt + 1'b1;
        if (raw != 2'b11 && cnt == CW'(FILT_CYCLES)) code <= raw;
      end
    end

    assign code_all[2*c +: 2] = code;
  end

  assign sel_word = code_all[rd_bank*WW +: WW];

  always_comb
    for (int i = 0; i < BANK_CH; i++) sel_sum[i] = &sel_word[2*i +: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word <= '1;
      rd_sum  <= '1;
    end else if (rd_stb) begin
      rd_word <= sel_word;
      rd_sum  <= sel_sum;
    end
  end

  assign fault_n = &code_all;
endmodule

// File: rtl/fault_diag_bank_chk.sv
module fault_diag_bank_chk #(
  parameter int BANK_CH     = 8,
  parameter int NBANK       = 2,
  parameter int FILT_CYCLES = 5000
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [BANK_CH*NBANK-1:0] flt_ovl,
  input logic [BANK_CH*NBANK-1:0] flt_open,
  input logic [BANK_CH*NBANK-1:0] flt_shg,
  input logic                     rd_stb,
  input logic [(NBANK>1 ? $clog2(NBANK) : 1)-1:0] rd_bank,
  input logic [2*BANK_CH-1:0]     rd_word,
  input logic [BANK_CH-1:0]       rd_sum,
  input logic                     fault_n
);
  localparam int RW = $clog2(FILT_CYCLES + 2);
  logic [RW-1:0] run;
  logic          any_raw;

  assign any_raw = |{flt_ovl, flt_open, flt_shg};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else if (!any_raw) run <= '0;
    else if (run != RW'(FILT_CYCLES + 1)) run <= run + 1'b1;

  AST_FLAG_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(run) >= RW'(FILT_CYCLES)); // R4

  AST_FLAG_RELEASE_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> $past(rd_stb)); // R6

  AST_REREAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && $past(rd_stb) && rd_bank == $past(rd_bank)) |=> rd_word == '1); // R7

  AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_word) && $stable(rd_sum)); // R10

  for (genvar i = 0; i < BANK_CH; i++) begin : g_sum
    AST_SUM_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sum[i] == &rd_word[2*i +: 2]); // R9
  end
endmodule

bind fault_diag_bank fault_diag_bank_chk #(
  .BANK_CH(BANK_CH), .NBANK(NBANK), .FILT_CYCLES(FILT_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_ovl(flt_ovl), .flt_open(flt_open),
  .flt_shg(flt_shg), .rd_stb(rd_stb), .rd_bank(rd_bank),
  .rd_word(rd_word), .rd_sum(rd_sum), .fault_n(fault_n)
);

// File: tb/fault_diag_bank_test.sv
`timescale 1ns/1ps
module fault_diag_bank_test;
  localparam int F = 6;
  logic clk = 0, rst_n = 0;
  logic [15:0] flt_ovl = '0, flt_open = '0, flt_shg = '0;
  logic rd_stb = 0;
  logic [0:0] rd_bank = '0;
  logic [15:0] rd_word;
  logic [7:0]  rd_sum;
  logic fault_n;
  int checks = 0, errors = 0;

  logic [1:0] mc [16];
  int         mcnt [16];
  logic [15:0] mw = '1;
  logic [7:0]  ms = '1;

  always #10 clk = ~clk;

  fault_diag_bank #(.BANK_CH(8), .NBANK(2), .FILT_CYCLES(F)) uut (
    .clk(clk), .rst_n(rst_n), .flt_ovl(flt_ovl), .flt_open(flt_open),
    .flt_shg(flt_shg), .rd_stb(rd_stb), .rd_bank(rd_bank),
    .rd_word(rd_word), .rd_sum(rd_sum), .fault_n(fault_n));

  function automatic logic [1:0] enc(input logic o, input logic s, input logic p);
    return o ? 2'b10 : s ? 2'b00 : p ? 2'b01 : 2'b11;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [1:0] nc [16];
    int         nn [16];
    for (int c = 0; c < 16; c++) begin
      logic [1:0] r;
      r = enc(flt_ovl[c], flt_shg[c], flt_open[c]);
      nc[c] = mc[c]; nn[c] = mcnt[c];
      if (rd_stb && (c / 8) == int'(rd_bank)) begin
        nc[c] = 2'b11; nn[c] = 0;
      end else begin
        if (r == 2'b11) nn[c] = 0;
        else if (mcnt[c] != F) nn[c] = mcnt[c] + 1;
        if (r != 2'b11 && mcnt[c] == F) nc[c] = r;
      end
    end
    if (rd_stb)
      for (int i = 0; i < 8; i++) begin
        mw[2*i +: 2] = mc[8*int'(rd_bank) + i];
        ms[i] = &mc[8*int'(rd_bank) + i];
      end
    for (int c = 0; c < 16; c++) begin mc[c] = nc[c]; mcnt[c] = nn[c]; end
  endtask

  function automatic logic model_flag();
    logic f = 1'b1;
    for (int c = 0; c < 16; c++) if (mc[c] != 2'b11) f = 1'b0;
    return f;
  endfunction

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R8 fault_n vs model", {31'b0, fault_n}, {31'b0, model_flag()});
    chk("R10 rd_word vs model", {16'b0, rd_word}, {16'b0, mw});
    chk("R9 rd_sum vs model", {24'b0, rd_sum}, {24'b0, ms});
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic rd(input int b);
    rd_stb = 1; rd_bank = b[0:0];
    cyc();
    rd_stb = 0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int c = 0; c < 16; c++) begin mc[c] = 2'b11; mcnt[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 fault_n after reset", {31'b0, fault_n}, 32'd1);
    chk("R1 rd_word after reset", {16'b0, rd_word}, 32'hFFFF);
    rd(0);
    chk("R1 bank0 healthy", {16'b0, rd_word}, 32'hFFFF);
    chk("R9 summary healthy", {24'b0, rd_sum}, 32'hFF);

    flt_ovl[3] = 1; cycles(F); flt_ovl[3] = 0; cyc();
    chk("R4 short fault not latched", {31'b0, fault_n}, 32'd1);
    flt_ovl[3] = 1; cycles(F + 1); flt_ovl[3] = 0;
    chk("R8 flag low after latch", {31'b0, fault_n}, 32'd0);
    cyc();
    rd(0);
    chk("R2 R3 overload ch3 code", {16'b0, rd_word}, 32'hFFBF);
    chk("R9 summary ch3", {24'b0, rd_sum}, 32'hF7);
    chk("R6 flag released by read", {31'b0, fault_n}, 32'd1);

    flt_ovl[1] = 1; cycles(4); flt_ovl[1] = 0; cyc(); flt_ovl[1] = 1; cycles(4); flt_ovl[1] = 0; cyc();
    chk("R4 gap restarts count", {31'b0, fault_n}, 32'd1);

    flt_open[10] = 1; cycles(F + 1); flt_open[10] = 0; flt_shg[10] = 1; cycles(F + 1); flt_shg[10] = 0; cyc();
    rd(0);
    chk("R6 other bank read empty", {16'b0, rd_word}, 32'hFFFF);
    chk("R6 bank1 still flagged", {31'b0, fault_n}, 32'd0);
    rd(1);
    chk("R5 short to ground overwrote open", {16'b0, rd_word}, 32'hFFCF);

    flt_ovl[15] = 1; flt_shg[15] = 1; flt_open[15] = 1; cycles(F + 1);
    flt_ovl[15] = 0; cycles(F + 1); flt_shg[15] = 0; flt_open[15] = 0; cyc();
    rd(1);
    chk("R2 R5 short to ground after overload", {16'b0, rd_word}, 32'h3FFF);
    flt_shg[15] = 1; flt_open[15] = 1; flt_ovl[15] = 1; cycles(F + 1);
    flt_shg[15] = 0; flt_open[15] = 0; flt_ovl[15] = 0; cyc();
    rd(1);
    chk("R2 overload has priority", {16'b0, rd_word}, 32'hBFFF);
    flt_open[9] = 1; cycles(F + 1); flt_open[9] = 0; cyc();
    rd(1);
    chk("R2 R3 open load ch9", {16'b0, rd_word}, 32'hFFF7);

    flt_ovl[0] = 1; cycles(F + 1);
    rd(0);
    chk("R6 R3 read ch0 while held", {16'b0, rd_word}, 32'hFFFE);
    cycles(F);
    chk("R7 not relatched early", {31'b0, fault_n}, 32'd1);
    cyc();
    chk("R7 relatched after delay", {31'b0, fault_n}, 32'd0);
    flt_ovl[0] = 0; cyc();
    rd(0);

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 20) == 0) begin
        int c = $urandom_range(0, 15);
        int t = $urandom_range(0, 3);
        flt_ovl[c] = (t == 1); flt_open[c] = (t == 2); flt_shg[c] = (t == 3);
      end
      if ($urandom_range(0, 14) == 0) begin
        rd_stb = 1; rd_bank = 1'($urandom_range(0, 1));
      end else rd_stb = 0;
      cyc();
    end
    rd_stb = 0;
    summary();
  end

  initial process::self().srandom(32'h5EED);
endmodule